// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit

This unit performs 8-bit unsigned multiplication and division over several clock cycles. A request brings two operand bytes, an operation select and a destination register index. The unit then works one bit per cycle: a shift-and-add loop for the product, and a restoring shift-and-subtract loop for the quotient. When it finishes it presents two result bytes and a write strobe for a pair of consecutive registers, index `rd` and `rd+1`. A multiply puts the low product byte in `rd` and the high byte in `rd+1`. A divide puts the quotient in `rd` and the remainder in `rd+1`.

The request side uses valid/ready. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. A request raised while `req_ready` is low is not held or queued: it is dropped. The sender therefore keeps `req_valid` asserted until it sees a transfer. The result side has no back-pressure. `res_done` is a single-cycle pulse that the register file must take in that cycle. The unit needs no stall, because it never holds more than one operation.

Division by zero has a defined result and also raises an error flag. A destination index that would put `rd+1` past the last register is reported, and that result is not written.

Top module: `smd_unit`

## Requirements
- R1: `req_ready` is high exactly when the unit is idle. It is high after reset and low from the edge that accepts a request until the edge that ends the `res_done` cycle.
- R2: A `req_valid` raised while `req_ready` is low has no effect. The result that follows is the one for the request that was accepted.
- R3: If a request is accepted on edge k, `res_done` is high for exactly the one cycle between edges k+8 and k+9. `req_ready` returns high after edge k+9.
- R4: Multiply (`req_op` = 0) returns product bits 7:0 on `res_lo` (for `rd`) and bits 15:8 on `res_hi` (for `rd+1`).
- R5: Divide (`req_op` = 1) with a nonzero divisor returns the quotient `a / b` on `res_lo` and the remainder `a % b` on `res_hi`.
- R6: Divide by zero returns 0xFF on `res_lo` and the dividend on `res_hi`, with `res_div0` high in the done cycle. `res_div0` is low at all other times.
- R7: In a multiply done cycle, `res_carry` equals product bit 15 and `res_zero` is high when the 16-bit product is zero. Both flags are low in a divide done cycle and outside done cycles.
- R8: `res_rd` gives the accepted `rd` in the done cycle. If `rd` = 31, `res_pair_err` is high and `res_wr_en` stays low. Otherwise `res_wr_en` is high in the done cycle. Both are low outside done cycles.
- R9: While reset is asserted, `req_ready` is high and `res_done`, `res_wr_en`, `res_lo`, `res_hi` and every flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, can take a request |
| req_op | input | 1 | 0 = multiply, 1 = divide |
| req_a | input | 8 | Multiplicand or dividend |
| req_b | input | 8 | Multiplier or divisor |
| req_rd | input | 5 | First register of the destination pair |
| res_done | output | 1 | One-cycle completion pulse |
| res_wr_en | output | 1 | Paired write strobe for `rd` and `rd+1` |
| res_rd | output | 5 | Destination index of the result |
| res_lo | output | 8 | Byte for `rd` |
| res_hi | output | 8 | Byte for `rd+1` |
| res_pair_err | output | 1 | Illegal pair (`rd` = 31) |
| res_div0 | output | 1 | Divide-by-zero flag |
| res_carry | output | 1 | Multiply product bit 15 |
| res_zero | output | 1 | Multiply product is zero |

## Verification
The multiply patterns are chosen to expose specific faults. A zero operand checks the zero flag. 255 × 255 sets every carry in the add chain and the top product bit. Single-bit multipliers check the byte split between `rd` and `rd+1`. A run of pseudo-random pairs covers mixed carries. The divide patterns each isolate one case: a dividend smaller than the divisor (quotient 0), a divisor of 1 (quotient equals dividend), a zero dividend, and a zero divisor (the error case). Exact multiples separate the restore and no-restore paths. Back-to-back requests, requests held during a busy period, and a destination index of 30 versus 31 check the handshake and the pair-range rule against a cycle-accurate reference model.

// File: rtl/smd_pkg.sv
package smd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } smd_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } smd_op_e;

endpackage

// File: rtl/smd_ctrl.sv
module smd_ctrl
  import smd_pkg::*;
#(
  parameter int ITER = 8,
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic load,
  output logic step,
  output logic done
);

  smd_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  assign req_ready = (state_q == ST_IDLE);
  assign load      = req_ready && req_valid;
  assign step      = (state_q == ST_RUN);
  assign done      = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_W'(ITER - 1);
          end
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_LOAD_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (step && !req_ready)); // R1

  AST_DONE_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(step)); // R3

endmodule

// File: rtl/smd_mul_path.sv
module smd_mul_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [2*W-1:0] prod
);

  logic [W-1:0] hi_q, lo_q, mcand_q;
  logic [W:0]   sum;

  assign sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
  assign prod = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
    end else if (load) begin
      hi_q    <= '0;
      lo_q    <= a;
      mcand_q <= b;
    end else if (step) begin
      {hi_q, lo_q} <= {sum, lo_q[W-1:1]};
    end
  end

  AST_MUL_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hi_q == '0)); // R4

endmodule

// File: rtl/smd_div_path.sv
module smd_div_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic [W-1:0] rem_q, quo_q, dsr_q;
  logic [W:0]   trial, diff;
  logic         fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, dsr_q};
  assign fits  = (trial >= {1'b0, dsr_q});
  assign quo   = quo_q;
  assign rem   = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= a;
      dsr_q <= b;
    end else if (step) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((dsr_q == '0) || (rem_q < dsr_q))); // R5

endmodule

// File: rtl/smd_unit.sv
module smd_unit
  import smd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  localparam int RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [DATA_W-1:0] req_a,
  input  logic [DATA_W-1:0] req_b,
  input  logic [RIDX_W-1:0] req_rd,
  output logic              res_done,
  output logic              res_wr_en,
  output logic [RIDX_W-1:0] res_rd,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic              res_pair_err,
  output logic              res_div0,
  output logic              res_carry,
  output logic              res_zero
);

  localparam logic [RIDX_W-1:0] LAST_RD = RIDX_W'(NUM_REGS - 1);

  logic load, step, done;
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0]   quo, rem;
  smd_op_e             op_q;
  logic [RIDX_W-1:0]   rd_q;
  logic                div0_q;
  logic                is_div;

  smd_ctrl #(.ITER(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .load      (load),
    .step      (step),
    .done      (done)
  );

  smd_mul_path #(.W(DATA_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a     (req_a),
    .b     (req_b),
    .prod  (prod)
  );

  smd_div_path #(.W(DATA_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a     (req_a),
    .b     (req_b),
    .quo   (quo),
    .rem   (rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_MUL;
      rd_q   <= '0;
      div0_q <= 1'b0;
    end else if (load) begin
      op_q   <= smd_op_e'(req_op);
      rd_q   <= req_rd;
      div0_q <= (req_b == '0);
    end
  end

  assign is_div       = (op_q == OP_DIV);
  assign res_done     = done;
  assign res_rd       = rd_q;
  assign res_lo       = is_div ? quo : prod[DATA_W-1:0];
  assign res_hi       = is_div ? rem : prod[2*DATA_W-1:DATA_W];
  assign res_pair_err = done && (rd_q == LAST_RD);
  assign res_wr_en    = done && (rd_q != LAST_RD);
  assign res_div0     = done && is_div && div0_q;
  assign res_carry    = done && !is_div && prod[2*DATA_W-1];
  assign res_zero     = done && !is_div && (prod == '0);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done); // R3

  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> !req_ready); // R1

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(res_done)); // R3

  AST_DIV0_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    res_div0 |-> (res_lo == '1)); // R6

  AST_ZERO_FLAG_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    res_zero |-> ((res_lo == '0) && (res_hi == '0))); // R7

  AST_NO_WRITE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_en |-> (res_rd != LAST_RD)); // R8

endmodule

// File: tb/smd_unit_test.sv
module smd_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_op = 1'b0;
  logic [7:0] req_a = '0;
  logic [7:0] req_b = '0;
  logic [4:0] req_rd = '0;
  logic       res_done, res_wr_en, res_pair_err, res_div0, res_carry, res_zero;
  logic [4:0] res_rd;
  logic [7:0] res_lo, res_hi;

  int vec = 0;
  int miss = 0;

  always #5 clk = ~clk;

  smd_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_a(req_a), .req_b(req_b), .req_rd(req_rd),
    .res_done(res_done), .res_wr_en(res_wr_en), .res_rd(res_rd),
    .res_lo(res_lo), .res_hi(res_hi), .res_pair_err(res_pair_err),
    .res_div0(res_div0), .res_carry(res_carry), .res_zero(res_zero)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: 0 idle, 1 working, 2 done
  int m_st = 0, m_cnt = 0, m_op = 0, m_a = 0, m_b = 0, m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) m_st <= 0;
    else begin
      case (m_st)
        0: if (req_valid) begin
             m_st <= 1; m_cnt <= 8; m_op <= int'(req_op);
             m_a <= int'(req_a); m_b <= int'(req_b); m_rd <= int'(req_rd);
           end
        1: begin
             if (m_cnt == 1) m_st <= 2;
             m_cnt <= m_cnt - 1;
           end
        default: m_st <= 0;
      endcase
    end
  end

  function automatic int exp_lo(int op, int a, int b);
    if (op == 0) return (a * b) % 256;
    if (b == 0)  return 255;
    return a / b;
  endfunction

  function automatic int exp_hi(int op, int a, int b);
    if (op == 0) return (a * b) / 256;
    if (b == 0)  return a;
    return a % b;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R9 reset ready", int'(req_ready), 1);
      chk("R9 reset done", int'(res_done), 0);
      chk("R9 reset wr_en", int'(res_wr_en), 0);
      chk("R9 reset data", int'({res_lo, res_hi}), 0);
      chk("R9 reset flags", int'({res_pair_err, res_div0, res_carry, res_zero}), 0);
    end else begin
      automatic bit dn = (m_st == 2);
      automatic int prd = m_a * m_b;
      chk("R1 req_ready", int'(req_ready), int'(m_st == 0));
      chk("R3 res_done", int'(res_done), int'(dn));
      chk("R8 res_wr_en", int'(res_wr_en), int'(dn && m_rd != 31));
      chk("R8 res_pair_err", int'(res_pair_err), int'(dn && m_rd == 31));
      chk("R6 res_div0", int'(res_div0), int'(dn && m_op == 1 && m_b == 0));
      chk("R7 res_carry", int'(res_carry), int'(dn && m_op == 0 && prd >= 32768));
      chk("R7 res_zero", int'(res_zero), int'(dn && m_op == 0 && prd == 0));
      if (dn) begin
        chk("R8 res_rd", int'(res_rd), m_rd);
        chk(m_op == 0 ? "R4 product low" : (m_b == 0 ? "R6 div0 quotient" : "R5 quotient"),
            int'(res_lo), exp_lo(m_op, m_a, m_b));
        chk(m_op == 0 ? "R4 product high" : (m_b == 0 ? "R6 div0 remainder" : "R5 remainder"),
            int'(res_hi), exp_hi(m_op, m_a, m_b));
      end
    end
  end

  task automatic issue(input int op, input int a, input int b, input int rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op[0]; req_a = a[7:0]; req_b = b[7:0]; req_rd = rd[4:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!res_done) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL R3 watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int seed = 32'h1d3f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 R7: multiply patterns
    issue(0, 0, 77, 4);
    issue(0, 255, 255, 16);
    issue(0, 15, 17, 2);
    issue(0, 1, 200, 8);
    issue(0, 128, 2, 10);
    issue(0, 3, 0, 0);
    // R5: divide patterns
    issue(1, 200, 7, 20);
    issue(1, 7, 200, 21);
    issue(1, 255, 1, 22);
    issue(1, 0, 5, 23);
    issue(1, 144, 12, 24);
    // R6: divide by zero
    issue(1, 37, 0, 18);
    issue(1, 0, 0, 18);
    // R8: pair at the end of the file and just below it
    issue(0, 9, 9, 31);
    issue(1, 90, 4, 30);

    // R2: request held while busy must be dropped
    issue(0, 12, 11, 6);
    req_valid = 1'b1; req_op = 1'b1; req_a = 8'd99; req_b = 8'd0; req_rd = 5'd31;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk("R2 ignored request low", int'(res_lo), 132);
    chk("R2 ignored request high", int'(res_hi), 0);
    chk("R2 ignored request rd", int'(res_rd), 6);

    // R1 R3: valid held across done, accepted as soon as ready returns
    issue(1, 250, 3, 12);
    req_valid = 1'b1; req_op = 1'b0; req_a = 8'd201; req_b = 8'd173; req_rd = 5'd13;
    wait_done();
    @(negedge clk);
    chk("R1 ready back after done", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after back-to-back accept", int'(req_ready), 0);

    // mixed pseudo-random operations
    for (int i = 0; i < 24; i++) begin
      seed = seed * 1103515245 + 12345;
      issue((seed >>> 20) & 1, (seed >>> 8) & 255, (seed >>> 16) & 255, (seed >>> 3) & 31);
    end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule